// File: doc/BRIEF.md
# Streaming Histogram Accumulator

This block counts how often each sample value occurs in a stream that delivers at most one sample per clock. Every bin lives in a two-port RAM. The sample value selects the bin, and the stored count is read out. That count is raised by one and written back to the same location. The read takes two clocks, so the sample value travels through a two-stage address pipeline and reaches the write port at the same moment its bin value comes back. When the same value returns before its own write-back has landed, a bypass path supplies the in-flight count instead of the stale RAM word. Counts stop at the all-ones value and do not wrap.

A run counter limits how many samples a run accepts. A one-cycle restart pulse clears the run counter so a new run can begin. A sweep select input takes the RAM address away from the sample stream and gives it to an internal address ramp. With the clear input high, the sweep writes zero to every bin it passes. With the clear input low, the sweep presents the bins on the output port in rising address order. One ramp therefore serves both to wipe the histogram and to unload it.

The default sample width is 10 bits, which gives 1024 bins and keeps elaboration small. A 14-bit deployment only overrides `SAMPLE_W`.

Top module: `hist_engine`

## Requirements
- R1: Each accepted sample adds exactly one to the bin whose address equals the sample value, and no other bin changes.
- R2: A value that repeats on consecutive accepted samples, or two accepted samples apart, is counted every time, with no lost increments.
- R3: A bin that holds the all-ones count (0xFFFF for the default 16-bit count) keeps that value when more samples hit it. It never wraps to zero.
- R4: A sample is accepted only when `smp_valid` is 1, `sweep_sel` is 0, `restart` is 0 and fewer than `run_len` samples have been accepted since the last restart or reset. `done` is 1 exactly when the accepted count is at least `run_len`, and it stays 1 until a restart.
- R5: A cycle with `restart` at 1 sets the accepted count to zero. In the next cycle `done` equals (`run_len` == 0).
- R6: With `sweep_sel` and `sweep_clr` both at 1 for at least 2^SAMPLE_W + 2 cycles, every bin reads back as zero afterwards.
- R7: While `sweep_sel` is 1, samples are ignored. No bin changes and the accepted count does not advance.
- R8: With `sweep_sel` at 1 and `sweep_clr` at 0, the k-th cycle of the sweep (counting from k = 0) produces, three clocks later, `out_valid` = 1, `out_addr` = k mod 2^SAMPLE_W and `out_count` = that bin's count. Consecutive outputs rise by one in address.
- R9: A cycle with `smp_valid` at 0 changes no bin and does not advance the accepted count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | SAMPLE_W | Sample value, used as bin address |
| run_len | input | LIMIT_W | Number of samples one run accepts |
| restart | input | 1 | One-cycle pulse that clears the run counter |
| sweep_sel | input | 1 | Hands the RAM address to the internal ramp |
| sweep_clr | input | 1 | During a sweep, write zero to each bin |
| done | output | 1 | Run limit reached |
| out_valid | output | 1 | Readout word valid |
| out_addr | output | SAMPLE_W | Bin address of the readout word |
| out_count | output | COUNT_W | Count stored in that bin |

## Verification
On every cycle the assertions check four things. Accumulating writes never carry a zero count, so a bin cannot wrap. `done` holds between restarts, and a restart leaves it set to `run_len == 0`. No nonzero word reaches the RAM once a sweep has been running for two cycles. Readout addresses rise by one, and the first readout word appears three clocks after the sweep begins. Whether the counts are correct can only be shown by the bench's scenarios, which compare full readouts against a reference histogram. These scenarios cover back-to-back and two-apart repeats, invalid and over-limit samples, samples sent during a sweep, and a bin driven past saturation across several restarted runs.

// File: rtl/hist_pkg.sv
package hist_pkg;

    // Operation carried by each pipeline slot
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_ACC  = 2'd1,
        OP_CLR  = 2'd2,
        OP_RD   = 2'd3
    } hist_op_e;

    localparam int DEF_SAMPLE_W = 10;
    localparam int DEF_COUNT_W  = 16;
    localparam int DEF_LIMIT_W  = 15;

    // True for slot kinds that write the RAM
    function automatic logic op_writes(hist_op_e op);
        return (op == OP_ACC) || (op == OP_CLR);
    endfunction

endpackage

// File: rtl/hist_ram.sv
module hist_ram #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q1;
    logic [DW-1:0] rd_q2;

    // Two-cycle read; a read in the same cycle as a write returns the old word
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rd_q1 <= mem[raddr];
        rd_q2 <= rd_q1;
    end

    assign rdata = rd_q2;
endmodule

// File: rtl/hist_sweep.sv
module hist_sweep #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst || !run) addr <= '0;
        else             addr <= addr + 1'b1;
    end
endmodule

// File: rtl/hist_run_ctr.sv
module hist_run_ctr #(
    parameter int LW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          offer,
    input  logic [LW-1:0] limit,
    output logic          accept,
    output logic          done
);
    logic [LW-1:0] taken;

    assign done   = (taken >= limit);
    assign accept = offer && !restart && !done;

    always_ff @(posedge clk) begin
        if (rst || restart) taken <= '0;
        else if (accept)    taken <= taken + 1'b1;
    end
endmodule

// File: rtl/hist_engine.sv
module hist_engine
    import hist_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int COUNT_W  = DEF_COUNT_W,
    parameter int LIMIT_W  = DEF_LIMIT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [LIMIT_W-1:0]  run_len,
    input  logic                restart,
    input  logic                sweep_sel,
    input  logic                sweep_clr,
    output logic                done,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_addr,
    output logic [COUNT_W-1:0]  out_count
);
    localparam logic [COUNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        hist_op_e            op;
        logic [SAMPLE_W-1:0] addr;
    } slot_t;

    typedef struct packed {
        logic                we;
        logic [SAMPLE_W-1:0] addr;
        logic [COUNT_W-1:0]  data;
    } wr_t;

    logic [SAMPLE_W-1:0] ramp;
    logic                accept;
    slot_t               entry, s1, s2;
    wr_t                 w1, w2;
    logic [COUNT_W-1:0]  ram_q;
    logic [COUNT_W-1:0]  base;
    logic                ram_we;
    logic                wr_acc;
    logic [COUNT_W-1:0]  ram_wdata;

    hist_sweep #(.AW(SAMPLE_W)) u_sweep (
        .clk  (clk),
        .rst  (rst),
        .run  (sweep_sel),
        .addr (ramp)
    );

    hist_run_ctr #(.LW(LIMIT_W)) u_run (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .offer   (smp_valid && !sweep_sel),
        .limit   (run_len),
        .accept  (accept),
        .done    (done)
    );

    // Slot entering the pipeline this cycle
    always_comb begin
        entry.addr = sweep_sel ? ramp : smp_data;
        if (sweep_sel)   entry.op = sweep_clr ? OP_CLR : OP_RD;
        else if (accept) entry.op = OP_ACC;
        else             entry.op = OP_IDLE;
    end

    hist_ram #(.AW(SAMPLE_W), .DW(COUNT_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (s2.addr),
        .wdata (ram_wdata),
        .raddr (entry.addr),
        .rdata (ram_q)
    );

    // Bypass: the two most recent writes are not yet visible in ram_q
    always_comb begin
        if (w1.we && (w1.addr == s2.addr))      base = w1.data;
        else if (w2.we && (w2.addr == s2.addr)) base = w2.data;
        else                                    base = ram_q;
    end

    assign ram_we    = op_writes(s2.op);
    assign wr_acc    = (s2.op == OP_ACC);
    assign ram_wdata = (s2.op == OP_CLR) ? '0
                     : (base == CNT_TOP)  ? CNT_TOP
                     : base + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1        <= '{op: OP_IDLE, addr: '0};
            s2        <= '{op: OP_IDLE, addr: '0};
            w1        <= '0;
            w2        <= '0;
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_count <= '0;
        end else begin
            s1        <= entry;
            s2        <= s1;
            w1        <= '{we: ram_we, addr: s2.addr, data: ram_wdata};
            w2        <= w1;
            out_valid <= (s2.op == OP_RD);
            out_addr  <= s2.addr;
            out_count <= base;
        end
    end
endmodule

// File: rtl/hist_engine_chk.sv
module hist_engine_chk #(
    parameter int SAMPLE_W = 10,
    parameter int COUNT_W  = 16,
    parameter int LIMIT_W  = 15
) (
    input logic                clk,
    input logic                rst,
    input logic                restart,
    input logic [LIMIT_W-1:0]  run_len,
    input logic                sweep_sel,
    input logic                sweep_clr,
    input logic                done,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_addr,
    input logic                ram_we,
    input logic                wr_acc,
    input logic [COUNT_W-1:0]  ram_wdata
);
    // R3
    bin_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wr_acc |-> ram_wdata != '0);

    // R4
    done_holds_chk: assert property (@(posedge clk) disable iff (rst)
        done && !restart |=> done || !$stable(run_len));

    // R5
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> done == (run_len == '0));

    // R6
    sweep_no_count_chk: assert property (@(posedge clk) disable iff (rst)
        sweep_sel && $past(sweep_sel) && $past(sweep_sel, 2) && ram_we |-> ram_wdata == '0);

    // R8
    read_order_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(out_valid) |-> out_addr == SAMPLE_W'($past(out_addr) + 1'b1));

    // R8
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sweep_sel) && !sweep_clr |=> ##2 out_valid);
endmodule

bind hist_engine hist_engine_chk #(
    .SAMPLE_W (SAMPLE_W),
    .COUNT_W  (COUNT_W),
    .LIMIT_W  (LIMIT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .run_len   (run_len),
    .sweep_sel (sweep_sel),
    .sweep_clr (sweep_clr),
    .done      (done),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .ram_we    (ram_we),
    .wr_acc    (wr_acc),
    .ram_wdata (ram_wdata)
);

// File: tb/hist_engine_bench.sv
`timescale 1ns/1ps
module hist_engine_bench;
    localparam int SW   = 10;
    localparam int CW   = 16;
    localparam int LW   = 15;
    localparam int BINS = 1 << SW;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          smp_valid;
    logic [SW-1:0] smp_data;
    logic [LW-1:0] run_len;
    logic          restart;
    logic          sweep_sel;
    logic          sweep_clr;
    logic          done;
    logic          out_valid;
    logic [SW-1:0] out_addr;
    logic [CW-1:0] out_count;

    int total = 0;
    int bad   = 0;
    int model [BINS];
    int taken = 0;
    bit finished = 0;
    logic [SW-1:0] exp_addr [$];
    int            exp_cnt  [$];

    always #2.5 clk = ~clk;

    hist_engine #(.SAMPLE_W(SW), .COUNT_W(CW), .LIMIT_W(LW)) u_hist_engine (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .run_len   (run_len),
        .restart   (restart),
        .sweep_sel (sweep_sel),
        .sweep_clr (sweep_clr),
        .done      (done),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .out_count (out_count)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare readout words with the scoreboard queue
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_addr.size() == 0) begin
                check("R8 unexpected readout word", 1, 0);
            end else begin
                logic [SW-1:0] ea;
                int ec;
                ea = exp_addr.pop_front();
                ec = exp_cnt.pop_front();
                check("R8 readout address", int'(out_addr), int'(ea));
                check("R1 bin count", int'(out_count), ec);
            end
        end
    end

    // Driver for one sample; the reference follows the acceptance rule of R4
    task automatic feed(int v, bit vld);
        smp_valid = vld;
        smp_data  = SW'(v);
        if (vld && taken < int'(run_len)) begin
            model[v] = model[v] + 1;
            taken++;
        end
        step();
    endtask

    task automatic do_restart();
        restart   = 1'b1;
        smp_valid = 1'b0;
        taken     = 0;
        step();
        restart = 1'b0;
    endtask

    task automatic do_clear();
        sweep_sel = 1'b1;
        sweep_clr = 1'b1;
        for (int k = 0; k < BINS + 2; k++) step();
        sweep_sel = 1'b0;
        sweep_clr = 1'b0;
        for (int k = 0; k < BINS; k++) model[k] = 0;
        step();
        step();
        step();
    endtask

    // Full readout; samples are driven meanwhile and must be ignored (R7)
    task automatic do_read();
        sweep_sel = 1'b1;
        sweep_clr = 1'b0;
        for (int k = 0; k < BINS; k++) begin
            smp_valid = 1'b1;
            smp_data  = SW'((k * 13) % BINS);
            exp_addr.push_back(SW'(k));
            exp_cnt.push_back(model[k] > CMAX ? CMAX : model[k]);
            step();
        end
        sweep_sel = 1'b0;
        smp_valid = 1'b0;
        for (int k = 0; k < 6; k++) step();
        check("R8 readout queue drained", exp_addr.size(), 0);
    endtask

    initial begin
        int seq [23] = '{5, 5, 5, 7, 9, 7, 7, 12, 12, 0, 1023, 4, 4, 4, 4, 8, 9, 2, 2, 2, 5, 5, 5};
        rst       = 1'b1;
        smp_valid = 1'b0;
        smp_data  = '0;
        run_len   = LW'(20);
        restart   = 1'b0;
        sweep_sel = 1'b0;
        sweep_clr = 1'b0;
        for (int k = 0; k < BINS; k++) model[k] = 0;
        step();
        step();
        rst = 1'b0;
        check("R4 done after reset", int'(done), 0);
        check("R8 out_valid after reset", int'(out_valid), 0);

        // R6: wipe, then confirm all bins read zero
        do_clear();
        do_read();

        // R1 R2 R9 R4: 20-sample run with repeats, an invalid and over-limit samples
        do_restart();
        check("R5 done after restart", int'(done), 0);
        for (int i = 0; i < 23; i++) begin
            feed(seq[i], 1'b1);
            if (i == 7) feed(33, 1'b0);   // R9: invalid sample
            if (i == 18) check("R4 done before limit", int'(done), 0);
            if (i == 19) check("R4 done at limit", int'(done), 1);
        end
        smp_valid = 1'b0;
        step();
        check("R4 done held", int'(done), 1);
        do_read();   // R7: samples during this sweep leave the model unchanged
        do_read();

        // R3: drive bin 1 past the top count over three runs
        run_len = LW'(30000);
        for (int r = 0; r < 3; r++) begin
            do_restart();
            check("R5 done cleared by restart", int'(done), 0);
            for (int i = 0; i < 30000; i++) feed(1, 1'b1);
            smp_valid = 1'b0;
            step();
            check("R4 done after long run", int'(done), 1);
        end
        do_read();

        // R6: clearing after saturation
        do_clear();
        do_read();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog expired: got 0 expected 1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule